// File: doc/BRIEF.md
# Endian-Configurable Byte-Addressable Data Memory

This block is the data store of a 32-bit load/store datapath. It holds whole 32-bit words, but every byte has an address of its own, so the word index advances once per four byte addresses. Each request carries an operation, a 32-bit base value and a signed 16-bit displacement. The block adds the base and the sign-extended displacement itself to form the effective byte address. It serves word loads, word stores, byte loads and byte stores.

A mode input chooses how the byte addresses inside a word map to the bit lanes of that word. One setting puts byte 0 at the most significant end and the other puts it at the least significant end. Word accesses give the same result in both settings. Byte accesses to the same stored word return different lanes depending on the setting.

Stores take effect at the rising clock edge that samples the request. Load results and the misalignment flag appear on registered outputs one cycle after the request. A word access whose effective address is not a multiple of four is refused: the store is dropped, the load returns zero, and the flag is raised.

Top module: `endian_data_mem`

## Requirements
- R1: The effective byte address is `req_base + sign_extend(req_offset)` modulo 2^32. The word index is effective-address bits [2 +: log2(DEPTH)]. Higher address bits are ignored, so addresses that differ only above the depth alias to the same word. For example, base 0 with offset 44 reaches the word at byte address 0x2C, and base 0x40 with offset 0xFFFC (-4) reaches byte address 0x3C.
- R2: A word store (op 2) at an aligned address writes all 32 bits of `req_wdata`. A word load (op 1) at an aligned address shows the stored word on `rsp_rdata` one clock after the request. The result is the same for both values of `big_endian`.
- R3: With `big_endian`=1, byte addresses whose low two bits are 0, 1, 2, 3 select bits [31:24], [23:16], [15:8], [7:0]. After 0x23456789 is stored at address 0, a byte load from address 1 returns 0x00000045.
- R4: With `big_endian`=0, low address bits 0, 1, 2, 3 select bits [7:0], [15:8], [23:16], [31:24]. After the same store, a byte load from address 1 returns 0x00000067.
- R5: A byte load (op 3) sign-extends the selected byte to 32 bits. Bytes 0x80 to 0xFF give upper bits of all ones, and 0x00 to 0x7F give upper bits of all zeros.
- R6: A byte store (op 4) writes `req_wdata[7:0]` into only the lane chosen by the address and the mode. The other three lanes of the word are unchanged.
- R7: A word load or word store whose effective address has nonzero low two bits raises `rsp_misaligned` one clock later. The store writes nothing, and the load returns 0. Byte accesses never raise the flag.
- R8: In the cycle after any request that is not a load, `rsp_rdata` is 0, and `rsp_misaligned` is 0 unless R7 applies.
- R9: While `rst_n` is low, `rsp_rdata` and `rsp_misaligned` are 0.
- R10: Operation encoding on `req_op`: 0 idle, 1 word load, 2 word store, 3 byte load, 4 byte store. Codes 5 to 7 behave as idle: they write nothing and return 0 with no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; stores and response registers update on the rising edge |
| rst_n | input | 1 | Active-low reset of the response registers |
| big_endian | input | 1 | 1: byte 0 is the most significant lane; 0: byte 0 is the least significant lane |
| req_op | input | 3 | Operation code (see R10) |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement added to the base |
| req_wdata | input | 32 | Store data; byte stores use bits [7:0] |
| rsp_rdata | output | 32 | Load result, one cycle after the request |
| rsp_misaligned | output | 1 | Set one cycle after a refused unaligned word access |

## Verification
The memory is first filled with distinct word patterns. These patterns then show whether word stores and loads land on the right index when the base and the signed displacement are combined in different ways: zero base, negative displacement, and high aliasing bits. The known word 0x23456789 is read back byte by byte in both modes, which separates the two lane orders. Words made of the bytes 0x80, 0xFF, 0x7F and 0x01 separate correct sign extension from zero extension. Byte stores followed by word loads show which lane was written and that its neighbours are unchanged. Unaligned word stores followed by aligned reloads show that the store was dropped. A long random mix of all eight operation codes, arbitrary bases and both modes is then compared against a behavioural model on every clock.

// File: rtl/edm_pkg.sv
package edm_pkg;

    localparam int WORD_W    = 32;
    localparam int LANE_W    = 8;
    localparam int LANES     = WORD_W / LANE_W;
    localparam int LANE_IX_W = $clog2(LANES);

    typedef enum logic [2:0] {
        EDM_IDLE = 3'd0,
        EDM_LDW  = 3'd1,
        EDM_STW  = 3'd2,
        EDM_LDB  = 3'd3,
        EDM_STB  = 3'd4
    } edm_op_e;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              misaligned;
    } edm_rsp_s;

endpackage

// File: rtl/edm_addr_gen.sv
// Effective address, word index and byte-lane selection.
module edm_addr_gen
    import edm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0]    base_i,
    input  logic [OFS_W-1:0]     offset_i,
    input  logic                 big_endian_i,
    output logic [IDX_W-1:0]     idx_o,
    output logic [LANE_IX_W-1:0] lane_o,
    output logic                 aligned_o
);

    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0]    eff_addr;
    logic [LANE_IX_W-1:0] byte_in_word;

    always_comb begin
        eff_addr     = base_i + {{EXT_W{offset_i[OFS_W-1]}}, offset_i};
        byte_in_word = eff_addr[LANE_IX_W-1:0];
        // Bits above the depth are dropped here (R1).
        idx_o        = eff_addr[LANE_IX_W +: IDX_W];
        aligned_o    = (byte_in_word == '0);
        // Big-endian numbering counts lanes from the top (R3, R4).
        lane_o       = big_endian_i ? ~byte_in_word : byte_in_word;
    end

endmodule

// File: rtl/edm_lane_ctrl.sv
// Write masks, store merge data and load extraction per byte lane.
module edm_lane_ctrl
    import edm_pkg::*;
(
    input  edm_op_e              op_i,
    input  logic [LANE_IX_W-1:0] lane_i,
    input  logic                 aligned_i,
    input  logic [WORD_W-1:0]    wdata_i,
    input  logic [WORD_W-1:0]    rword_i,
    output logic [LANES-1:0]     be_o,
    output logic [WORD_W-1:0]    wword_o,
    output logic [WORD_W-1:0]    ldata_o,
    output logic                 misaligned_o
);

    logic              word_op;
    logic [LANE_W-1:0] sel_byte;

    genvar k;
    generate
        for (k = 0; k < LANES; k++) begin : g_lane
            always_comb begin
                be_o[k] = ((op_i == EDM_STW) && aligned_i) ||
                          ((op_i == EDM_STB) && (lane_i == LANE_IX_W'(k)));
                wword_o[k*LANE_W +: LANE_W] = (op_i == EDM_STB) ?
                          wdata_i[LANE_W-1:0] : wdata_i[k*LANE_W +: LANE_W];
            end
        end
    endgenerate

    always_comb begin
        word_op      = (op_i == EDM_LDW) || (op_i == EDM_STW);
        misaligned_o = word_op && !aligned_i;
        sel_byte     = rword_i[lane_i*LANE_W +: LANE_W];
        case (op_i)
            EDM_LDW: ldata_o = aligned_i ? rword_i : '0;
            EDM_LDB: ldata_o = {{(WORD_W-LANE_W){sel_byte[LANE_W-1]}}, sel_byte};
            default: ldata_o = '0;
        endcase
    end

endmodule

// File: rtl/edm_word_store.sv
// Word array with per-lane write enables and asynchronous read.
module edm_word_store
    import edm_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic [LANES-1:0]     be_i,
    input  logic [WORD_W-1:0]    wword_i,
    output logic [WORD_W-1:0]    rword_o
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb rword_o = mem_q[idx_i];

    always_ff @(posedge clk) begin
        for (int k = 0; k < LANES; k++) begin
            if (be_i[k]) begin
                mem_q[idx_i][k*LANE_W +: LANE_W] <= wword_i[k*LANE_W +: LANE_W];
            end
        end
    end

    // A write touches either one lane or the whole word.
    assert_lane_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (be_i != '0) |-> (($countones(be_i) == 1) || (be_i == '1)));

endmodule

// File: rtl/endian_data_mem.sv
module endian_data_mem
    import edm_pkg::*;
#(
    parameter int DEPTH  = 256,   // power of two
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_misaligned
);

    localparam int IDX_W = $clog2(DEPTH);

    edm_op_e              op;
    logic [IDX_W-1:0]     idx;
    logic [LANE_IX_W-1:0] lane;
    logic                 aligned;
    logic [LANES-1:0]     be;
    logic [WORD_W-1:0]    wword;
    logic [WORD_W-1:0]    rword;
    logic [WORD_W-1:0]    ldata;
    logic                 mis;
    edm_rsp_s             rsp_d, rsp_q;

    always_comb op = edm_op_e'(req_op);

    edm_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W)) u_addr (
        .base_i       (req_base),
        .offset_i     (req_offset),
        .big_endian_i (big_endian),
        .idx_o        (idx),
        .lane_o       (lane),
        .aligned_o    (aligned)
    );

    edm_lane_ctrl u_lane (
        .op_i         (op),
        .lane_i       (lane),
        .aligned_i    (aligned),
        .wdata_i      (req_wdata),
        .rword_i      (rword),
        .be_o         (be),
        .wword_o      (wword),
        .ldata_o      (ldata),
        .misaligned_o (mis)
    );

    edm_word_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (idx),
        .be_i    (be),
        .wword_i (wword),
        .rword_o (rword)
    );

    always_comb begin
        rsp_d            = rsp_q;
        rsp_d.rdata      = ldata;
        rsp_d.misaligned = mis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    always_comb begin
        rsp_rdata      = rsp_q.rdata;
        rsp_misaligned = rsp_q.misaligned;
    end

    assert_misaligned_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (((op == EDM_STW) || (op == EDM_LDW)) && !aligned) |-> (be == '0));

    assert_misaligned_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_misaligned |-> (rsp_rdata == '0));

    assert_byte_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == EDM_LDB) |=> (rsp_rdata[WORD_W-1:LANE_W] == {(WORD_W-LANE_W){rsp_rdata[LANE_W-1]}}));

    assert_no_load_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op != EDM_LDW) && (op != EDM_LDB)) |=> (rsp_rdata == '0));

endmodule

// File: tb/endian_data_mem_test.sv
`timescale 1ns/1ps
module endian_data_mem_test;

    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_misaligned;

    logic [31:0] model [DEPTH];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    endian_data_mem uut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_misaligned(rsp_misaligned)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after comparing.
    task automatic issue(input logic [2:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] wd,
                         input logic mode, input string tag);
        logic [31:0] ea, exp_d;
        logic        exp_m;
        int          idx, lane;
        logic [7:0]  b;
        req_op = op; req_base = base; req_offset = off;
        req_wdata = wd; big_endian = mode;
        ea    = base + 32'($signed(off));
        idx   = int'((ea >> 2) % DEPTH);
        lane  = mode ? 3 - int'(ea[1:0]) : int'(ea[1:0]);
        exp_d = 0; exp_m = 0;
        case (op)
            3'd1: if (ea[1:0] != 0) exp_m = 1; else exp_d = model[idx];
            3'd2: if (ea[1:0] != 0) exp_m = 1; else model[idx] = wd;
            3'd3: begin
                b = 8'(model[idx] >> (lane * 8));
                exp_d = 32'($signed(b));
            end
            3'd4: model[idx] = (model[idx] & ~(32'hFF << (lane * 8)))
                               | (32'(wd[7:0]) << (lane * 8));
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        check(tag, "rdata", rsp_rdata, exp_d);
        check(tag, "misaligned", 32'(rsp_misaligned), 32'(exp_m));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "reset rdata", rsp_rdata, 32'h0);
        check("R9", "reset misaligned", 32'(rsp_misaligned), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill with distinct patterns (R2).
        for (int i = 0; i < DEPTH; i++)
            issue(3'd2, 32'(i * 4), 16'h0, 32'(i) * 32'h01010101 ^ 32'hA5C3_0F96, 1'b0, "R2");
        for (int i = 0; i < DEPTH; i += 37)
            issue(3'd1, 32'(i * 4), 16'h0, 32'h0, 1'b1, "R2");

        // Second word read at byte address 4 (R2).
        issue(3'd2, 32'h0, 16'd4, 32'hF2F1AC07, 1'b0, "R2");
        issue(3'd1, 32'h4, 16'd0, 32'h0, 1'b1, "R2");
        // Base 0 plus 44 lands at 0x2C (R1).
        issue(3'd2, 32'h0, 16'd44, 32'hCAFE_0B0E, 1'b0, "R1");
        issue(3'd1, 32'h2C, 16'd0, 32'h0, 1'b0, "R1");
        // Negative displacement (R1).
        issue(3'd1, 32'h40, 16'hFFFC, 32'h0, 1'b0, "R1");
        // High bits alias onto low words (R1).
        issue(3'd1, 32'h8000_0000 + 32'(DEPTH * 4) + 32'h2C, 16'd0, 32'h0, 1'b0, "R1");

        // Lane order in both modes (R3, R4).
        issue(3'd2, 32'h0, 16'd0, 32'h23456789, 1'b0, "R2");
        issue(3'd3, 32'h0, 16'd1, 32'h0, 1'b1, "R3");
        issue(3'd3, 32'h0, 16'd1, 32'h0, 1'b0, "R4");
        for (int a = 0; a < 4; a++) begin
            issue(3'd3, 32'(a), 16'd0, 32'h0, 1'b1, "R3");
            issue(3'd3, 32'(a), 16'd0, 32'h0, 1'b0, "R4");
        end

        // Sign extension (R5).
        issue(3'd2, 32'h10, 16'd0, 32'h80FF7F01, 1'b0, "R2");
        for (int a = 0; a < 4; a++)
            issue(3'd3, 32'h10 + 32'(a), 16'd0, 32'h0, 1'b0, "R5");

        // Byte stores touch one lane only (R6).
        issue(3'd4, 32'h11, 16'd0, 32'hFFFF_FF5A, 1'b1, "R6");
        issue(3'd1, 32'h10, 16'd0, 32'h0, 1'b1, "R6");
        issue(3'd4, 32'h13, 16'd0, 32'h0000_00C3, 1'b0, "R6");
        issue(3'd1, 32'h10, 16'd0, 32'h0, 1'b0, "R6");

        // Refused word accesses (R7).
        issue(3'd2, 32'h0, 16'd2, 32'hDEAD_BEEF, 1'b0, "R7");
        issue(3'd1, 32'h0, 16'd0, 32'h0, 1'b0, "R7");
        issue(3'd1, 32'h4, 16'd1, 32'h0, 1'b1, "R7");
        issue(3'd3, 32'h3, 16'd0, 32'h0, 1'b1, "R7");

        // Idle and unused codes (R8, R10).
        for (int c = 5; c < 8; c++) begin
            issue(3'(c), 32'h10, 16'd0, 32'h1234_5678, 1'b0, "R10");
            issue(3'd1, 32'h10, 16'd0, 32'h0, 1'b0, "R10");
        end
        issue(3'd0, 32'h10, 16'd0, 32'h0, 1'b0, "R8");

        // Random mix against the model.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            issue(op, $urandom(), 16'($urandom()), $urandom(), 1'($urandom()),
                  op == 3'd3 ? "R5" : op == 3'd4 ? "R6" : op == 3'd0 ? "R8" :
                  op > 3'd4 ? "R10" : "R2");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule